// File: doc/BRIEF.md
# ADC Power Mode Controller

This block sequences the power state of a data converter's digital side. It decodes a two-bit operating-mode field from a configuration register and an active-high power-down pin, and it drives enables for the voltage reference, the bias networks, the sample clock and the serial link. It also drives a tri-state control for the output drivers and a `ready` flag that tells the rest of the chip that conversion data is valid.

There are two low-power states. The deep one shuts everything down and floats the outputs. The light one keeps the reference, the clock and the serial link alive so the converter can come back quickly. Leaving either state passes through a wake-up phase whose length is a parameter: `PD_WAKE` cycles after a deep power-down, when internal capacitors must recharge, and the shorter `SB_WAKE` cycles after standby. A new low-power request that arrives during a wake-up phase cancels it at once.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `cfg_mode` carries bits [1:0] of configuration register 0x08 and is decoded as 2'b00 = normal, 2'b01 = full power-down, 2'b10 = standby, 2'b11 = normal. When `pdn_pin` is low, the decoded request takes effect at the next rising clock edge.
- R2: When `pdn_pin` is high at a rising edge, the block is in full power-down after that edge, whatever `cfg_mode` holds.
- R3: In full power-down, `ref_en`, `bias_en`, `clk_en` and `link_en` are 0, `out_hiz` is 1 and `ready` is 0.
- R4: In standby, `ref_en`, `clk_en` and `link_en` are 1, `bias_en` is 0, `out_hiz` is 0 and `ready` is 0.
- R5: `ready` is 0 after the first rising edge at which a power-down or standby request is sampled.
- R6: When a normal request is sampled while in full power-down, a wake-up phase begins. In that phase `ref_en`, `bias_en` and `clk_en` are 1, `link_en` is 0, `out_hiz` is 1 and `ready` is 0. The phase lasts exactly `PD_WAKE` cycles before the active state.
- R7: When a normal request is sampled while in standby, a wake-up phase begins. In that phase all enables are 1, `out_hiz` is 0 and `ready` is 0. The phase lasts exactly `SB_WAKE` cycles before the active state.
- R8: A power-down or standby request sampled during either wake-up phase moves the block straight to the requested state at that edge, cancelling the countdown.
- R9: The reset is synchronous and active-low. It puts the block in the wake-up phase that follows a power-down. With a normal request held, `ready` first goes to 1 after the `PD_WAKE`-th rising edge at which `rst_n` is high.
- R10: In the active state, all four enables are 1, `out_hiz` is 0 and `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Mode field from the configuration register |
| pdn_pin | input | 1 | External power-down pin, active high |
| ref_en | output | 1 | Reference and reference buffer enable |
| bias_en | output | 1 | Bias network enable |
| clk_en | output | 1 | Sample clock enable |
| link_en | output | 1 | Serial link enable |
| out_hiz | output | 1 | Output drivers to high impedance |
| ready | output | 1 | Converter data valid |

## Verification
The hardest situation to reach is a low-power request that lands part way through a wake-up countdown. This matters most when the request is for the other low-power state, for example standby arriving while the block recovers from deep power-down. Random stimulus reaches it only when a mode change falls inside a short window. So the bench drives a directed sequence that releases power-down, waits a few cycles and then requests standby. It also changes the mode and pin often enough that random runs keep cutting wake-up phases short at varied counts. A reference model in the bench follows every cycle and checks all six outputs against it.

// File: rtl/pwr_pkg.sv
// Package: shared types for the power mode controller.
// Assumes: three request kinds and five controller states.
package pwr_pkg;

    typedef enum logic [1:0] {
        REQ_RUN = 2'd0,
        REQ_PD  = 2'd1,
        REQ_SB  = 2'd2
    } pwr_req_e;

    typedef enum logic [2:0] {
        ST_ACTIVE  = 3'd0,
        ST_PDOWN   = 3'd1,
        ST_STBY    = 3'd2,
        ST_WAKE_PD = 3'd3,
        ST_WAKE_SB = 3'd4
    } pwr_state_e;

    typedef struct packed {
        logic ref_en;
        logic bias_en;
        logic clk_en;
        logic link_en;
        logic out_hiz;
        logic ready;
    } pwr_out_t;

endpackage

// File: rtl/pwr_req_decode.sv
// Module: pwr_req_decode
// Turns the register mode field and the pin into one request.
// Assumes: the pin has priority over the field, and the reserved code 11
// means normal.
module pwr_req_decode
    import pwr_pkg::*;
(
    input  logic [1:0] mode_field,
    input  logic       pin_pd,
    output pwr_req_e   req
);

    // Merge the pin and the field into a single request.
    always_comb begin
        if (pin_pd) begin
            req = REQ_PD;
        end else begin
            case (mode_field)
                2'b01:   req = REQ_PD;
                2'b10:   req = REQ_SB;
                default: req = REQ_RUN;
            endcase
        end
    end

endmodule

// File: rtl/pwr_wake_timer.sv
// Module: pwr_wake_timer
// Down-counter for the wake-up wait. It loads a value and steps down to zero.
// Assumes: the caller loads (wait - 1); reset loads RST_VAL.
module pwr_wake_timer #(
    parameter int CNT_W   = 5,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    // Load takes priority over decrement; the count holds at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && dec && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R6

    AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val))); // R7

endmodule

// File: rtl/pwr_mode_fsm.sv
// Module: pwr_mode_fsm
// The state machine for the power modes and the wake-up phases.
// Assumes: a low-power request always wins; wake phases run out on timer zero.
module pwr_mode_fsm
    import pwr_pkg::*;
#(
    parameter int PD_WAKE = 20,
    parameter int SB_WAKE = 5,
    parameter int CNT_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pwr_req_e         req,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             tmr_dec,
    output pwr_state_e       state
);

    localparam logic [CNT_W-1:0] PD_LOAD = CNT_W'(PD_WAKE - 1);
    localparam logic [CNT_W-1:0] SB_LOAD = CNT_W'(SB_WAKE - 1);

    pwr_state_e state_nx;

    // Choose the next state and the timer action.
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = PD_LOAD;
        tmr_dec  = 1'b0;
        if (req == REQ_PD) begin
            state_nx = ST_PDOWN;
        end else if (req == REQ_SB) begin
            state_nx = ST_STBY;
        end else begin
            case (state)
                ST_PDOWN: begin
                    state_nx = ST_WAKE_PD;
                    tmr_load = 1'b1;
                    tmr_val  = PD_LOAD;
                end
                ST_STBY: begin
                    state_nx = ST_WAKE_SB;
                    tmr_load = 1'b1;
                    tmr_val  = SB_LOAD;
                end
                ST_WAKE_PD, ST_WAKE_SB: begin
                    if (tmr_zero) begin
                        state_nx = ST_ACTIVE;
                    end else begin
                        tmr_dec = 1'b1;
                    end
                end
                default: state_nx = ST_ACTIVE;
            endcase
        end
    end

    // State register; reset enters the recovery that follows power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_WAKE_PD;
        end else begin
            state <= state_nx;
        end
    end

    AST_ACTIVE_VIA_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && $past(state) != ST_ACTIVE) |->
        ($past(state) == ST_WAKE_PD || $past(state) == ST_WAKE_SB)); // R6

    AST_ABORT_TO_STBY: assert property (@(posedge clk) disable iff (!rst_n)
        (req == REQ_SB) |=> (state == ST_STBY)); // R8

    AST_ABORT_TO_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (req == REQ_PD) |=> (state == ST_PDOWN)); // R8

endmodule

// File: rtl/pwr_out_map.sv
// Module: pwr_out_map
// Maps a controller state to the enable, tri-state and ready pattern.
// Assumes: the state input comes from a register, so the outputs are glitch-free.
module pwr_out_map
    import pwr_pkg::*;
(
    input  pwr_state_e state,
    output pwr_out_t   outs
);

    // One fixed output pattern per state.
    always_comb begin
        case (state)
            ST_ACTIVE:  outs = '{ref_en:1'b1, bias_en:1'b1, clk_en:1'b1,
                                 link_en:1'b1, out_hiz:1'b0, ready:1'b1};
            ST_STBY:    outs = '{ref_en:1'b1, bias_en:1'b0, clk_en:1'b1,
                                 link_en:1'b1, out_hiz:1'b0, ready:1'b0};
            ST_WAKE_PD: outs = '{ref_en:1'b1, bias_en:1'b1, clk_en:1'b1,
                                 link_en:1'b0, out_hiz:1'b1, ready:1'b0};
            ST_WAKE_SB: outs = '{ref_en:1'b1, bias_en:1'b1, clk_en:1'b1,
                                 link_en:1'b1, out_hiz:1'b0, ready:1'b0};
            default:    outs = '{ref_en:1'b0, bias_en:1'b0, clk_en:1'b0,
                                 link_en:1'b0, out_hiz:1'b1, ready:1'b0};
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Module: pwr_mode_ctrl (top)
// Power mode controller: decodes the requests, sequences the wake-up and
// drives the enables.
// Assumes: cfg_mode and pdn_pin are already synchronous to clk; PD_WAKE > SB_WAKE >= 1.
module pwr_mode_ctrl
    import pwr_pkg::*;
#(
    parameter int PD_WAKE = 20,
    parameter int SB_WAKE = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_mode,
    input  logic       pdn_pin,
    output logic       ref_en,
    output logic       bias_en,
    output logic       clk_en,
    output logic       link_en,
    output logic       out_hiz,
    output logic       ready
);

    localparam int CNT_W = (PD_WAKE > 1) ? $clog2(PD_WAKE) : 1;

    pwr_req_e         req;
    pwr_state_e       state;
    pwr_out_t         outs;
    logic             tmr_load;
    logic             tmr_dec;
    logic             tmr_zero;
    logic [CNT_W-1:0] tmr_val;

    pwr_req_decode u_dec (
        .mode_field (cfg_mode),
        .pin_pd     (pdn_pin),
        .req        (req)
    );

    pwr_mode_fsm #(
        .PD_WAKE (PD_WAKE),
        .SB_WAKE (SB_WAKE),
        .CNT_W   (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .tmr_dec  (tmr_dec),
        .state    (state)
    );

    pwr_wake_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (PD_WAKE - 1)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    pwr_out_map u_map (
        .state (state),
        .outs  (outs)
    );

    // Drive the output ports from the mapped pattern.
    always_comb begin
        ref_en  = outs.ref_en;
        bias_en = outs.bias_en;
        clk_en  = outs.clk_en;
        link_en = outs.link_en;
        out_hiz = outs.out_hiz;
        ready   = outs.ready;
    end

    AST_PIN_FORCES_PD: assert property (@(posedge clk) disable iff (!rst_n)
        pdn_pin |=> (out_hiz && !ref_en && !bias_en && !clk_en && !link_en)); // R2

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (pdn_pin || cfg_mode == 2'b01 || cfg_mode == 2'b10) |=> !ready); // R5

    AST_STBY_KEEPS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (!pdn_pin && cfg_mode == 2'b10) |=> (ref_en && link_en && !out_hiz && !bias_en)); // R4

    AST_READY_NOT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!out_hiz && ref_en && bias_en && clk_en && link_en)); // R10

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
// Bench for pwr_mode_ctrl: a cycle reference model, directed corner cases and
// seeded random mode and pin activity.
module tb_pwr_mode_ctrl;

    localparam int PDW = 20;
    localparam int SBW = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic       pdn_pin = 1'b0;
    logic       ref_en, bias_en, clk_en, link_en, out_hiz, ready;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Model states: 0 active, 1 power-down, 2 standby, 3 wake from pd, 4 wake from sb
    int m_st = 3;
    int m_cnt = PDW - 1;

    pwr_mode_ctrl #(.PD_WAKE(PDW), .SB_WAKE(SBW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .pdn_pin(pdn_pin),
        .ref_en(ref_en), .bias_en(bias_en), .clk_en(clk_en),
        .link_en(link_en), .out_hiz(out_hiz), .ready(ready)
    );

    always #2 clk = ~clk;

    // Request from the field and the pin: 0 run, 1 power-down, 2 standby (R1, R2)
    function automatic int req_of(input logic [1:0] m, input logic p);
        if (p) return 1;
        if (m == 2'b01) return 1;
        if (m == 2'b10) return 2;
        return 0;
    endfunction

    // Expected {ref, bias, clk, link, hiz, ready} per state
    function automatic logic [5:0] exp_of(input int s);
        case (s)
            0: return 6'b111101; // R10
            1: return 6'b000010; // R3
            2: return 6'b101100; // R4
            3: return 6'b111010; // R6
            default: return 6'b111100; // R7
        endcase
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            0: return "R10";
            1: return "R3";
            2: return "R4";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Reference model, one step per rising edge
    always @(posedge clk) begin
        int r;
        r = req_of(cfg_mode, pdn_pin);
        if (!rst_n) begin
            m_st  <= 3;
            m_cnt <= PDW - 1;
        end else if (r == 1) begin
            m_st <= 1;
        end else if (r == 2) begin
            m_st <= 2;
        end else if (m_st == 1) begin
            m_st <= 3; m_cnt <= PDW - 1;
        end else if (m_st == 2) begin
            m_st <= 4; m_cnt <= SBW - 1;
        end else if (m_st == 3 || m_st == 4) begin
            if (m_cnt == 0) m_st <= 0;
            else m_cnt <= m_cnt - 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Move to the next falling edge and compare every output with the model
    task automatic tick();
        logic [5:0] act;
        @(negedge clk);
        act = {ref_en, bias_en, clk_en, link_en, out_hiz, ready};
        check(act === exp_of(m_st), tag_of(m_st), act, exp_of(m_st));
    endtask

    task automatic drive(input logic [1:0] m, input logic p);
        cfg_mode = m;
        pdn_pin  = p;
    endtask

    task automatic ready_is(input logic e, input string req);
        check(ready === e, req, {5'b0, ready}, {5'b0, e});
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        // R9: the reset state is the recovery phase that follows power-down
        repeat (3) tick();
        check({ref_en, bias_en, clk_en, link_en, out_hiz, ready} === 6'b111010, "R9",
              {ref_en, bias_en, clk_en, link_en, out_hiz, ready}, 6'b111010);
        rst_n = 1'b1;
        for (int i = 1; i <= PDW; i++) begin
            tick();
            ready_is(i == PDW, "R9");
        end
        // R2: the pin wins over a normal field; R5: ready falls at once
        drive(2'b00, 1'b1);
        tick();
        ready_is(1'b0, "R5");
        check(out_hiz === 1'b1, "R2", {5'b0, out_hiz}, 6'd1);
        // R1: with the pin released, field 01 still holds power-down
        drive(2'b01, 1'b0);
        repeat (3) tick();
        check(out_hiz === 1'b1 && ref_en === 1'b0, "R1", {4'b0, out_hiz, ref_en}, 6'b10);
        // R8: standby during the power-down recovery goes straight to standby
        drive(2'b00, 1'b0);
        repeat (4) tick();
        ready_is(1'b0, "R6");
        drive(2'b10, 1'b0);
        tick();
        check(link_en === 1'b1 && bias_en === 1'b0 && out_hiz === 1'b0, "R8",
              {3'b0, link_en, bias_en, out_hiz}, 6'b100);
        // R7, R1: reserved code 11 wakes from standby in SB_WAKE cycles
        drive(2'b11, 1'b0);
        tick();
        for (int i = 1; i <= SBW; i++) begin
            tick();
            ready_is(i == SBW, "R7");
        end
        // R8: power-down pin during the standby recovery
        drive(2'b10, 1'b0);
        tick();
        drive(2'b00, 1'b0);
        repeat (2) tick();
        drive(2'b00, 1'b1);
        tick();
        check(out_hiz === 1'b1 && clk_en === 1'b0, "R8", {4'b0, out_hiz, clk_en}, 6'b10);
        // Seeded random mode and pin activity, checked against the model every cycle
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(7) == 0) begin
                if ($urandom_range(1) == 0) cfg_mode = 2'b00;
                else cfg_mode = 2'($urandom_range(3));
            end
            if ($urandom_range(15) == 0) pdn_pin = ~pdn_pin;
            if ($urandom_range(999) == 0) rst_n = 1'b0;
            else rst_n = 1'b1;
            tick();
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check
    initial begin
        #(4 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule